// File: doc/BRIEF.md
# Clear-and-Merge Bus Selector

This block picks one of eight W-bit sources and puts it on a shared output bus. It does not use a case or priority multiplexer. The 3-bit select is first decoded into one one-hot enable per source. Each source has its own holding register. That register's synchronous clear is driven by its decoder output, so any register that is not selected is forced to zero on every clock edge. Since at most one register can hold a nonzero value, a plain OR of all registers gives the selected value. The OR is built in two levels: pairs first, then a four-way merge.

The selected register captures its data word on an edge where the load strobe is high. If the strobe is low, it keeps what it holds. A global enable taken low clears every slot. A synchronous reset does the same. The output is a pure OR of register contents, so it changes only on clock edges and follows a new select one cycle later.

Top module: `clrsel_bus`

## Requirements
- R1: When `en` is high, exactly one slot enable is active: the one whose index equals `sel`. When `en` is low, no slot enable is active.
- R2: On every clock edge, each slot that is not enabled is cleared to zero, so at most one slot register is nonzero at any time.
- R3: Source k occupies bits [k*W +: W] of `src_data`. After an edge with `en`=1, `load`=1 and `sel`=k, `bus_out` equals that slice as sampled at the edge.
- R4: After an edge with `en`=1, `load`=0 and `sel` equal to its value at the previous edge, `bus_out` keeps its previous value.
- R5: After an edge with `en`=1, `load`=0 and `sel` different from its value at the previous edge, `bus_out` is zero, because the newly chosen slot was cleared while it was unselected.
- R6: After an edge with `en`=0, `bus_out` is zero, whatever `load`, `sel` and `src_data` are.
- R7: After an edge with `rst`=1, `bus_out` is zero, even when `load` and `en` are high.
- R8: No source has priority. Each of the eight select values delivers its own source word unchanged, even while all other sources carry different nonzero data.
- R9: `bus_out` depends only on register contents. A change on `src_data` or `sel` between edges leaves it unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global enable; low clears all slots |
| load | input | 1 | Capture strobe for the selected slot |
| sel | input | SEL_W (3) | Index of the source to pass |
| src_data | input | NUM_SRC*W (128) | Source words, source k at bits [k*W +: W] |
| bus_out | output | W (16) | OR of all slot registers |

## Verification
The checker assumes that `rst` is high at the first clock edge. It also assumes that `sel`, `en`, `load` and `src_data` are at known values at every edge, because the decoder and the clear paths treat an unknown select as no match. The bench holds reset for the opening cycles. It changes every input a short time after the rising edge, and it draws random values only from fully defined ranges, so every edge sees settled, known inputs. Enable is kept high most of the time, so that loads, holds and select changes happen often enough to exercise the behaviour that depends on the previous select value.

// File: rtl/clrsel_pkg.sv
package clrsel_pkg;
   // Width of an index able to address n items, never below one bit.
   function automatic int idx_bits(input int n);
      int b;
      b = 1;
      while ((1 << b) < n) b++;
      return b;
   endfunction
endpackage

// File: rtl/clrsel_dec.sv
module clrsel_dec #(
   parameter int NUM_SRC = 8,
   parameter int SEL_W   = 3
) (
   input  logic               en,
   input  logic [SEL_W-1:0]   sel,
   output logic [NUM_SRC-1:0] slot_en
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_match
      assign slot_en[i] = en && (sel == SEL_W'(i));
   end
endmodule

// File: rtl/clrsel_slots.sv
module clrsel_slots #(
   parameter int NUM_SRC = 8,
   parameter int W       = 16
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          load,
   input  logic [NUM_SRC-1:0]            slot_en,
   input  logic [NUM_SRC*W-1:0]          src_data,
   output logic [NUM_SRC-1:0][W-1:0]     slot_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
      logic clr;
      assign clr = rst || !slot_en[i];
      always_ff @(posedge clk) begin
         if (clr)       slot_q[i] <= '0;
         else if (load) slot_q[i] <= src_data[i*W +: W];
      end
   end
endmodule

// File: rtl/clrsel_merge.sv
module clrsel_merge #(
   parameter int NUM_SRC = 8,
   parameter int W       = 16
) (
   input  logic [NUM_SRC-1:0][W-1:0] slot_q,
   output logic [W-1:0]              merged
);
   localparam int NPAIR = NUM_SRC / 2;

   logic [NPAIR-1:0][W-1:0] pair_or;

   for (genvar j = 0; j < NPAIR; j++) begin : g_pair
      assign pair_or[j] = slot_q[2*j] | slot_q[2*j+1];
   end

   always_comb begin
      merged = '0;
      for (int j = 0; j < NPAIR; j++) merged = merged | pair_or[j];
   end
endmodule

// File: rtl/clrsel_bus.sv
module clrsel_bus #(
   parameter int NUM_SRC = 8,
   parameter int W       = 16,
   parameter int SEL_W   = clrsel_pkg::idx_bits(NUM_SRC)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic                 load,
   input  logic [SEL_W-1:0]     sel,
   input  logic [NUM_SRC*W-1:0] src_data,
   output logic [W-1:0]         bus_out
);
   if (W < 1) begin : g_bad_w
      $error("clrsel_bus: W must be at least 1");
   end
   if (NUM_SRC < 2 || (NUM_SRC % 2) != 0) begin : g_bad_n
      $error("clrsel_bus: NUM_SRC must be even and at least 2");
   end
   if ((1 << SEL_W) < NUM_SRC) begin : g_bad_sel
      $error("clrsel_bus: SEL_W too narrow for NUM_SRC");
   end

   logic [NUM_SRC-1:0]        dec_en;
   logic [NUM_SRC-1:0][W-1:0] src_q;

   clrsel_dec #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_dec (
      .en(en), .sel(sel), .slot_en(dec_en)
   );

   clrsel_slots #(.NUM_SRC(NUM_SRC), .W(W)) u_slots (
      .clk(clk), .rst(rst), .load(load), .slot_en(dec_en),
      .src_data(src_data), .slot_q(src_q)
   );

   clrsel_merge #(.NUM_SRC(NUM_SRC), .W(W)) u_merge (
      .slot_q(src_q), .merged(bus_out)
   );
endmodule

// File: rtl/clrsel_chk.sv
module clrsel_chk #(
   parameter int NUM_SRC = 8,
   parameter int W       = 16,
   parameter int SEL_W   = 3
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      en,
   input logic                      load,
   input logic [SEL_W-1:0]          sel,
   input logic [NUM_SRC*W-1:0]      src_data,
   input logic [W-1:0]              bus_out,
   input logic [NUM_SRC-1:0]        dec_en,
   input logic [NUM_SRC-1:0][W-1:0] src_q
);
   logic [NUM_SRC-1:0] nz;
   logic [W-1:0]       pick;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_nz
      assign nz[i] = |src_q[i];
   end
   assign pick = src_data[sel*W +: W];

   AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (rst) en |-> $onehot(dec_en)); // R1
   AST_DEC_IDLE: assert property (@(posedge clk) disable iff (rst) !en |-> (dec_en == '0)); // R1
   AST_ONE_LIVE: assert property (@(posedge clk) disable iff (rst) $onehot0(nz)); // R2
   AST_LOAD_PASS: assert property (@(posedge clk) disable iff (rst) (en && load) |=> (bus_out == $past(pick))); // R3
   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst) (en && !load && sel == $past(sel)) |=> $stable(bus_out)); // R4
   AST_NEWSEL_ZERO: assert property (@(posedge clk) disable iff (rst) (en && !load && sel != $past(sel)) |=> (bus_out == '0)); // R5
   AST_EN_CLEAR: assert property (@(posedge clk) disable iff (rst) !en |=> (bus_out == '0)); // R6
   AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (bus_out == '0)); // R7
endmodule

bind clrsel_bus clrsel_chk #(.NUM_SRC(NUM_SRC), .W(W), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst(rst), .en(en), .load(load), .sel(sel), .src_data(src_data),
   .bus_out(bus_out), .dec_en(dec_en), .src_q(src_q)
);

// File: tb/sim_clrsel_bus.sv
`timescale 1ns/1ps
module sim_clrsel_bus;
   localparam int NUM_SRC = 8;
   localparam int W       = 16;
   localparam int SEL_W   = 3;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 en = 1'b0;
   logic                 load = 1'b0;
   logic [SEL_W-1:0]     sel = '0;
   logic [NUM_SRC*W-1:0] src_data = '0;
   logic [W-1:0]         bus_out;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   clrsel_bus #(.NUM_SRC(NUM_SRC), .W(W)) u0 (
      .clk(clk), .rst(rst), .en(en), .load(load), .sel(sel),
      .src_data(src_data), .bus_out(bus_out)
   );

   // Behavioural reference: what the bus should show after each edge.
   logic [W-1:0]     exp_out = '0;
   logic [SEL_W-1:0] prev_sel = '0;
   always @(posedge clk) begin
      if (rst || !en)         exp_out <= '0;
      else if (load)          exp_out <= src_data[sel*W +: W];
      else if (sel != prev_sel) exp_out <= '0;
      prev_sel <= sel;
   end

   task automatic check(input string req);
      n_vec++;
      if (bus_out !== exp_out) begin
         n_bad++;
         $display("FAIL %s: bus_out=%h expected=%h at %0t", req, bus_out, exp_out, $time);
      end
   endtask

   // Drive inputs, take one edge, compare just after it.
   task automatic step(input logic r, input logic e, input logic l,
                       input logic [SEL_W-1:0] s, input string req);
      rst = r; en = e; load = l; sel = s;
      @(posedge clk);
      #2;
      check(req);
   endtask

   task automatic fill_distinct(input int salt);
      for (int k = 0; k < NUM_SRC; k++)
         src_data[k*W +: W] = W'(16'h1111 * (k + 1) ^ salt);
   endtask

   initial begin
      #1;
      fill_distinct(0);
      step(1, 1, 1, 3'd2, "R7");
      step(1, 1, 1, 3'd5, "R7");
      // R8 and R3: every select value delivers its own word.
      for (int k = 0; k < NUM_SRC; k++) step(0, 1, 1, SEL_W'(k), "R8");
      for (int k = NUM_SRC - 1; k >= 0; k--) step(0, 1, 1, SEL_W'(k), "R3");
      // R9: input change between edges leaves the bus alone.
      fill_distinct(16'h5a5a);
      sel = 3'd6;
      #1;
      check("R9");
      // R4: hold with load low, same select.
      step(0, 1, 1, 3'd4, "R3");
      step(0, 1, 0, 3'd4, "R4");
      step(0, 1, 0, 3'd4, "R4");
      // R5: new select without load gives zero.
      step(0, 1, 0, 3'd1, "R5");
      step(0, 1, 0, 3'd1, "R4");
      step(0, 1, 1, 3'd1, "R3");
      // R6: global enable low clears.
      step(0, 0, 1, 3'd1, "R6");
      step(0, 1, 0, 3'd1, "R6");
      step(0, 1, 1, 3'd7, "R3");
      // R7: reset overrides a load.
      step(1, 1, 1, 3'd7, "R7");
      step(0, 1, 0, 3'd7, "R7");
      // R2: random mix, at most one slot may show through the OR.
      for (int i = 0; i < 400; i++) begin
         for (int k = 0; k < NUM_SRC; k++) src_data[k*W +: W] = W'($urandom);
         step(($urandom % 50) == 0, ($urandom % 8) != 0, ($urandom % 3) != 0,
              SEL_W'($urandom % 8), "R2");
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected end before timeout");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule